// File: doc/BRIEF.md
# Thread Block Compaction Controller

This controller runs a whole thread block through divergent code as a single unit. One reconvergence stack serves the entire block. Each entry holds a program counter, the reconvergence PC and one active bit per thread of the block. The warps that are currently executing are not fixed. They are produced by compacting the top entry's active bits. Each thread keeps its home lane, and the threads of each lane column are stacked into as few warps as possible.

Warps report branch outcomes and reconvergence arrivals by their current warp slot. A branch outcome carries a per-lane taken mask and the target, fall-through and reconvergence PCs. Nothing changes in the stack until every valid slot has reported, so the block acts as a barrier. Once the last slot reports, the controller does one of two things:

- If the branch diverged, it splits the block into two paths and pushes them.
- If it did not diverge, it moves the PC and keeps the arrangement.

When all slots of a path reach its reconvergence PC, the path entry is popped. The entry below then resumes with its own mask, so the block's full mask returns at the outermost reconvergence point.

Top module: `tbc_ctrl`

## Requirements
- R1: On `start_i` while idle, the stack holds one entry with the start PC, reconvergence PC all ones and every thread active. Slot k then carries original warp k in all lanes, and `warp_cnt_o` equals the warp count. `start_i` while busy has no effect.
- R2: The stack changes only after every valid slot has reported the same kind of event. A repeated report from a slot, a report naming a slot at or above `warp_cnt_o`, and a report of the other kind while a barrier is partly filled are all ignored.
- R3: Compaction keeps each thread in its lane. Thread t belongs to original warp t/NL and lane t%NL, and is bit t of `top_mask_o`. Within lane l, the active threads fill slots 0, 1, ... in increasing original warp order. `slot_act_o[k][l]` shows that a thread is present, and `slot_src_o[k][l]` gives its original warp.
- R4: `warp_cnt_o` equals the largest number of active threads in any lane column. `slot_valid_o` has exactly the low `warp_cnt_o` bits set.
- R5: A divergent branch turns the top entry into the reconvergence entry (reconvergence PC, old reconvergence PC, old mask). It then pushes the not-taken entry (fall-through PC) and after that the taken entry (target PC), both with the branch's reconvergence PC. Depth grows by 2, and the taken path executes first.
- R6: A branch where all active threads agree sets the top PC to the target (all taken) or to the fall-through (none taken). Depth and the warp arrangement stay the same.
- R7: When all slots report reconvergence, the top entry is popped and the entry below resumes with its own mask. After the outermost reconvergence the block's full mask and static warps return.
- R8: A reconvergence report on the last entry empties the stack. `busy_o`, `depth_o`, `warp_cnt_o`, `slot_valid_o` and the top outputs then go to zero.
- R9: While `rst_ni` is low the block is idle with an empty stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch the block |
| start_pc_i | input | PC_W | Launch PC |
| br_valid_i | input | 1 | Branch outcome from one slot |
| br_slot_i | input | WID_W | Reporting slot |
| br_taken_i | input | NL | Per-lane taken mask |
| br_target_i | input | PC_W | Taken PC |
| br_fall_i | input | PC_W | Not-taken PC |
| br_reconv_i | input | PC_W | Reconvergence PC of the branch |
| rc_valid_i | input | 1 | Slot reached the reconvergence PC |
| rc_slot_i | input | WID_W | Reporting slot |
| slot_valid_o | output | NW | Slots in use |
| slot_act_o | output | NW x NL | Lane occupancy per slot |
| slot_src_o | output | NW x NL x WID_W | Original warp per slot lane |
| warp_cnt_o | output | CNT_W | Number of compacted warps |
| top_pc_o | output | PC_W | Top entry PC |
| top_rpc_o | output | PC_W | Top entry reconvergence PC |
| top_mask_o | output | NW*NL | Top entry thread mask |
| depth_o | output | DW | Stack depth |
| busy_o | output | 1 | Block in flight |
| arrived_o | output | NW | Slots that have reported |

## Verification
The bench targets the barrier edges:

- A duplicate report, a report from an out-of-range slot, and a reconvergence report mixed into a branch barrier must each leave the stack alone. A design that counted any of them would split or pop early, before every warp had arrived.

The bench checks the full slot map on a divergent branch in both paths, taken and not-taken:

- A design that ignored home lanes, or filled slots in the wrong warp order, would show the wrong warp ID in some lane.
- A design that counted total threads instead of the fullest column would report the wrong warp count.

The bench also covers the other paths through the stack:

- Uniform branches, both all-taken and none-taken, must keep the depth. A design that pushed them would grow the stack.
- The final pop must return to idle, and a second launch while busy must be ignored.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  typedef enum logic [2:0] {
    STK_HOLD,
    STK_INIT,
    STK_JUMP,
    STK_SPLIT,
    STK_POP
  } stk_op_e;
endpackage

// File: rtl/tbc_compactor.sv
module tbc_compactor #(
  parameter int NW    = 3,
  parameter int NL    = 4,
  parameter int WID_W = 2,
  parameter int CNT_W = 2
) (
  input  logic [NW*NL-1:0]                     mask_i,
  output logic [NW-1:0][NL-1:0]                act_o,
  output logic [NW-1:0][NL-1:0][WID_W-1:0]     src_o,
  output logic [CNT_W-1:0]                     cnt_o
);
  // slot k of lane l takes the k-th active thread of that column
  always_comb begin : p_pack
    logic [CNT_W-1:0] seen;
    act_o = '0;
    src_o = '0;
    for (int l = 0; l < NL; l++) begin
      seen = '0;
      for (int w = 0; w < NW; w++) begin
        if (mask_i[w*NL+l]) begin
          for (int k = 0; k < NW; k++) begin
            if (seen == CNT_W'(k)) begin
              act_o[k][l] = 1'b1;
              src_o[k][l] = WID_W'(w);
            end
          end
          seen = seen + CNT_W'(1);
        end
      end
    end
  end

  always_comb begin : p_count
    logic [CNT_W-1:0] col;
    cnt_o = '0;
    for (int l = 0; l < NL; l++) begin
      col = '0;
      for (int w = 0; w < NW; w++) col = col + CNT_W'(mask_i[w*NL+l]);
      if (col > cnt_o) cnt_o = col;
    end
  end
endmodule

// File: rtl/tbc_stack.sv
module tbc_stack
  import tbc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 8,
  parameter int NT    = 12,
  parameter int DW    = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  stk_op_e         op_i,
  input  logic [PC_W-1:0] pc_a_i,
  input  logic [PC_W-1:0] pc_b_i,
  input  logic [PC_W-1:0] pc_c_i,
  input  logic [NT-1:0]   nt_mask_i,
  input  logic [NT-1:0]   tk_mask_i,
  output logic [PC_W-1:0] top_pc_o,
  output logic [PC_W-1:0] top_rpc_o,
  output logic [NT-1:0]   top_mask_o,
  output logic [DW-1:0]   depth_o
);
  logic [DEPTH-1:0][PC_W-1:0] pc_q;
  logic [DEPTH-1:0][PC_W-1:0] rpc_q;
  logic [DEPTH-1:0][NT-1:0]   mask_q;
  logic [DW-1:0]              depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      rpc_q   <= '0;
      mask_q  <= '0;
      depth_q <= '0;
    end else begin
      unique case (op_i)
        STK_INIT: begin
          depth_q   <= DW'(1);
          pc_q[0]   <= pc_a_i;
          rpc_q[0]  <= '1;
          mask_q[0] <= '1;
        end
        STK_JUMP: begin
          for (int i = 0; i < DEPTH; i++)
            if (DW'(i) + DW'(1) == depth_q) pc_q[i] <= pc_a_i;
        end
        STK_SPLIT: begin
          for (int i = 0; i < DEPTH; i++) begin
            if (DW'(i) + DW'(1) == depth_q) pc_q[i] <= pc_a_i;
            if (DW'(i) == depth_q) begin
              pc_q[i]   <= pc_b_i;
              rpc_q[i]  <= pc_a_i;
              mask_q[i] <= nt_mask_i;
            end
            if (DW'(i) == depth_q + DW'(1)) begin
              pc_q[i]   <= pc_c_i;
              rpc_q[i]  <= pc_a_i;
              mask_q[i] <= tk_mask_i;
            end
          end
          depth_q <= depth_q + DW'(2);
        end
        STK_POP:  depth_q <= depth_q - DW'(1);
        default: ;
      endcase
    end
  end

  always_comb begin
    top_pc_o   = '0;
    top_rpc_o  = '0;
    top_mask_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (DW'(i) + DW'(1) == depth_q) begin
        top_pc_o   = pc_q[i];
        top_rpc_o  = rpc_q[i];
        top_mask_o = mask_q[i];
      end
    end
  end

  assign depth_o = depth_q;
endmodule

// File: rtl/tbc_barrier.sv
module tbc_barrier #(
  parameter int NW    = 3,
  parameter int NL    = 4,
  parameter int WID_W = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clear_i,
  input  logic [NW-1:0]                    slot_valid_i,
  input  logic [NW-1:0][NL-1:0]            act_i,
  input  logic [NW-1:0][NL-1:0][WID_W-1:0] src_i,
  input  logic                             br_valid_i,
  input  logic [WID_W-1:0]                 br_slot_i,
  input  logic [NL-1:0]                    br_taken_i,
  input  logic                             rc_valid_i,
  input  logic [WID_W-1:0]                 rc_slot_i,
  output logic [NW-1:0]                    arrived_o,
  output logic                             br_done_o,
  output logic                             rc_done_o,
  output logic [NW*NL-1:0]                 taken_o
);
  logic [NW-1:0]    arrived_q, br_sel, rc_sel, arr_nx;
  logic [NW*NL-1:0] taken_q;
  logic             is_br_q;  // kind of the partly filled barrier
  logic             br_ok, rc_ok;

  always_comb begin
    br_sel = '0;
    rc_sel = '0;
    for (int k = 0; k < NW; k++) begin
      br_sel[k] = (br_slot_i == WID_W'(k));
      rc_sel[k] = (rc_slot_i == WID_W'(k));
    end
    br_ok = br_valid_i && |(br_sel & slot_valid_i & ~arrived_q) &&
            (arrived_q == '0 || is_br_q);
    rc_ok = !br_ok && rc_valid_i && |(rc_sel & slot_valid_i & ~arrived_q) &&
            (arrived_q == '0 || !is_br_q);
    arr_nx = arrived_q | (br_ok ? br_sel : '0) | (rc_ok ? rc_sel : '0);
    br_done_o = br_ok && (arr_nx == slot_valid_i);
    rc_done_o = rc_ok && (arr_nx == slot_valid_i);

    // scatter the slot's lane outcomes back to home threads
    taken_o = taken_q;
    if (br_ok) begin
      for (int k = 0; k < NW; k++)
        for (int l = 0; l < NL; l++)
          for (int w = 0; w < NW; w++)
            if (br_sel[k] && act_i[k][l] && src_i[k][l] == WID_W'(w))
              taken_o[w*NL+l] = br_taken_i[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arrived_q <= '0;
      taken_q   <= '0;
      is_br_q   <= 1'b0;
    end else if (clear_i || br_done_o || rc_done_o) begin
      arrived_q <= '0;
      taken_q   <= '0;
      is_br_q   <= 1'b0;
    end else if (br_ok) begin
      arrived_q <= arr_nx;
      taken_q   <= taken_o;
      is_br_q   <= 1'b1;
    end else if (rc_ok) begin
      arrived_q <= arr_nx;
      is_br_q   <= 1'b0;
    end
  end

  assign arrived_o = arrived_q;
endmodule

// File: rtl/tbc_ctrl.sv
module tbc_ctrl
  import tbc_pkg::*;
#(
  parameter int  NW    = 3,
  parameter int  NL    = 4,
  parameter int  PC_W  = 8,
  parameter int  DEPTH = 8,
  localparam int WID_W = (NW > 1) ? $clog2(NW) : 1,
  localparam int CNT_W = $clog2(NW + 1),
  localparam int DW    = $clog2(DEPTH + 1),
  localparam int NT    = NW * NL
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             start_i,
  input  logic [PC_W-1:0]                  start_pc_i,
  input  logic                             br_valid_i,
  input  logic [WID_W-1:0]                 br_slot_i,
  input  logic [NL-1:0]                    br_taken_i,
  input  logic [PC_W-1:0]                  br_target_i,
  input  logic [PC_W-1:0]                  br_fall_i,
  input  logic [PC_W-1:0]                  br_reconv_i,
  input  logic                             rc_valid_i,
  input  logic [WID_W-1:0]                 rc_slot_i,
  output logic [NW-1:0]                    slot_valid_o,
  output logic [NW-1:0][NL-1:0]            slot_act_o,
  output logic [NW-1:0][NL-1:0][WID_W-1:0] slot_src_o,
  output logic [CNT_W-1:0]                 warp_cnt_o,
  output logic [PC_W-1:0]                  top_pc_o,
  output logic [PC_W-1:0]                  top_rpc_o,
  output logic [NT-1:0]                    top_mask_o,
  output logic [DW-1:0]                    depth_o,
  output logic                             busy_o,
  output logic [NW-1:0]                    arrived_o
);
  stk_op_e         op;
  logic [PC_W-1:0] pc_a, pc_b, pc_c;
  logic [NT-1:0]   nt_mask, tk_mask, taken;
  logic            br_done, rc_done, launch;

  tbc_stack #(.DEPTH(DEPTH), .PC_W(PC_W), .NT(NT), .DW(DW)) u_stack (
    .clk_i, .rst_ni,
    .op_i(op), .pc_a_i(pc_a), .pc_b_i(pc_b), .pc_c_i(pc_c),
    .nt_mask_i(nt_mask), .tk_mask_i(tk_mask),
    .top_pc_o, .top_rpc_o, .top_mask_o, .depth_o
  );

  tbc_compactor #(.NW(NW), .NL(NL), .WID_W(WID_W), .CNT_W(CNT_W)) u_pack (
    .mask_i(top_mask_o), .act_o(slot_act_o), .src_o(slot_src_o), .cnt_o(warp_cnt_o)
  );

  tbc_barrier #(.NW(NW), .NL(NL), .WID_W(WID_W)) u_bar (
    .clk_i, .rst_ni, .clear_i(launch),
    .slot_valid_i(slot_valid_o), .act_i(slot_act_o), .src_i(slot_src_o),
    .br_valid_i, .br_slot_i, .br_taken_i, .rc_valid_i, .rc_slot_i,
    .arrived_o, .br_done_o(br_done), .rc_done_o(rc_done), .taken_o(taken)
  );

  for (genvar k = 0; k < NW; k++) begin : g_slot
    assign slot_valid_o[k] = |slot_act_o[k];
  end

  assign busy_o = (depth_o != '0);
  assign launch = start_i && !busy_o;

  always_comb begin
    op      = STK_HOLD;
    pc_a    = '0;
    pc_b    = '0;
    pc_c    = '0;
    tk_mask = top_mask_o & taken;
    nt_mask = top_mask_o & ~taken;
    if (launch) begin
      op   = STK_INIT;
      pc_a = start_pc_i;
    end else if (br_done) begin
      if (tk_mask == '0) begin
        op   = STK_JUMP;
        pc_a = br_fall_i;
      end else if (nt_mask == '0) begin
        op   = STK_JUMP;
        pc_a = br_target_i;
      end else begin
        op   = STK_SPLIT;
        pc_a = br_reconv_i;
        pc_b = br_fall_i;
        pc_c = br_target_i;
      end
    end else if (rc_done) begin
      op = STK_POP;
    end
  end
endmodule

// File: rtl/tbc_ctrl_chk.sv
module tbc_ctrl_chk #(
  parameter int NW    = 3,
  parameter int NL    = 4,
  parameter int PC_W  = 8,
  parameter int DEPTH = 8,
  parameter int WID_W = 2,
  parameter int CNT_W = 2,
  parameter int DW    = 4
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             start_i,
  input logic [NW-1:0]                    slot_valid_o,
  input logic [NW-1:0][NL-1:0]            slot_act_o,
  input logic [CNT_W-1:0]                 warp_cnt_o,
  input logic [NW*NL-1:0]                 top_mask_o,
  input logic [DW-1:0]                    depth_o,
  input logic                             busy_o,
  input logic [NW-1:0]                    arrived_o
);
  logic [NL-1:0][NW-1:0] col_act, col_mask;
  always_comb begin
    for (int l = 0; l < NL; l++)
      for (int w = 0; w < NW; w++) begin
        col_act[l][w]  = slot_act_o[w][l];
        col_mask[l][w] = top_mask_o[w*NL+l];
      end
  end

  for (genvar l = 0; l < NL; l++) begin : g_lane
    a_r3_lane_cover: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(col_act[l]) == $countones(col_mask[l]));
  end

  a_r4_slots_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(slot_valid_o) == int'(warp_cnt_o) &&
    (slot_valid_o & (slot_valid_o + NW'(1))) == '0);

  a_r2_arrived_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arrived_o & ~slot_valid_o) == '0);

  a_r5_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(depth_o) <= DEPTH);

  a_r5_depth_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (depth_o == $past(depth_o) || depth_o == $past(depth_o) + DW'(2) ||
                depth_o + DW'(1) == $past(depth_o)));

  a_r7_bottom_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o == DW'(1) |-> &top_mask_o);

  a_r8_idle_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (warp_cnt_o == '0 && slot_valid_o == '0 && arrived_o == '0));
endmodule

bind tbc_ctrl tbc_ctrl_chk #(
  .NW(NW), .NL(NL), .PC_W(PC_W), .DEPTH(DEPTH),
  .WID_W(WID_W), .CNT_W(CNT_W), .DW(DW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .slot_valid_o(slot_valid_o), .slot_act_o(slot_act_o), .warp_cnt_o(warp_cnt_o),
  .top_mask_o(top_mask_o), .depth_o(depth_o), .busy_o(busy_o), .arrived_o(arrived_o)
);

// File: tb/tbc_ctrl_test.sv
`timescale 1ns/1ps
module tbc_ctrl_test;
  localparam int NW = 3, NL = 4, PC_W = 8, DEPTH = 8;
  localparam logic [7:0] FALL = 8'h20, RECONV = 8'h60;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic start_i = 0, br_valid_i = 0, rc_valid_i = 0;
  logic [7:0] start_pc_i = 0, br_target_i = 0;
  logic [1:0] br_slot_i = 0, rc_slot_i = 0;
  logic [3:0] br_taken_i = 0;
  logic [NW-1:0] slot_valid_o, arrived_o;
  logic [NW-1:0][NL-1:0] slot_act_o;
  logic [NW-1:0][NL-1:0][1:0] slot_src_o;
  logic [1:0] warp_cnt_o;
  logic [7:0] top_pc_o, top_rpc_o;
  logic [11:0] top_mask_o;
  logic [3:0] depth_o;
  logic busy_o;

  tbc_ctrl #(.NW(NW), .NL(NL), .PC_W(PC_W), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni, .start_i, .start_pc_i,
    .br_valid_i, .br_slot_i, .br_taken_i, .br_target_i,
    .br_fall_i(FALL), .br_reconv_i(RECONV),
    .rc_valid_i, .rc_slot_i,
    .slot_valid_o, .slot_act_o, .slot_src_o, .warp_cnt_o,
    .top_pc_o, .top_rpc_o, .top_mask_o, .depth_o, .busy_o, .arrived_o
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // kind: 0 start, 1 branch, 2 reconvergence
  typedef struct packed {
    logic [1:0] kind;
    logic [1:0] slot;
    logic [3:0] mask;
    logic [7:0] pc;
    logic [3:0] req;
    logic [1:0] cnt;
    logic [3:0] depth;
    logic [7:0] top;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 2'd0, 4'h0, 8'h10, 4'd1, 2'd3, 4'd1, 8'h10}, // R1 launch
    '{2'd1, 2'd0, 4'h3, 8'h40, 4'd2, 2'd3, 4'd1, 8'h10}, // R2 partial
    '{2'd1, 2'd1, 4'h6, 8'h40, 4'd2, 2'd3, 4'd1, 8'h10},
    '{2'd1, 2'd1, 4'h6, 8'h40, 4'd2, 2'd3, 4'd1, 8'h10}, // R2 duplicate
    '{2'd2, 2'd2, 4'h0, 8'h00, 4'd2, 2'd3, 4'd1, 8'h10}, // R2 wrong kind
    '{2'd1, 2'd2, 4'h1, 8'h40, 4'd5, 2'd2, 4'd3, 8'h40}, // R5 split
    '{2'd2, 2'd2, 4'h0, 8'h00, 4'd2, 2'd2, 4'd3, 8'h40}, // R2 slot beyond count
    '{2'd1, 2'd0, 4'h7, 8'h48, 4'd6, 2'd2, 4'd3, 8'h40},
    '{2'd1, 2'd1, 4'h3, 8'h48, 4'd6, 2'd2, 4'd3, 8'h48}, // R6 all taken
    '{2'd2, 2'd0, 4'h0, 8'h00, 4'd7, 2'd2, 4'd3, 8'h48},
    '{2'd2, 2'd1, 4'h0, 8'h00, 4'd7, 2'd3, 4'd2, 8'h20}, // R7 pop to not-taken
    '{2'd2, 2'd0, 4'h0, 8'h00, 4'd7, 2'd3, 4'd2, 8'h20},
    '{2'd2, 2'd1, 4'h0, 8'h00, 4'd7, 2'd3, 4'd2, 8'h20},
    '{2'd2, 2'd2, 4'h0, 8'h00, 4'd7, 2'd3, 4'd1, 8'h60}, // R7 full block
    '{2'd2, 2'd0, 4'h0, 8'h00, 4'd8, 2'd3, 4'd1, 8'h60},
    '{2'd2, 2'd1, 4'h0, 8'h00, 4'd8, 2'd3, 4'd1, 8'h60},
    '{2'd2, 2'd2, 4'h0, 8'h00, 4'd8, 2'd0, 4'd0, 8'h00}, // R8 exit
    '{2'd0, 2'd0, 4'h0, 8'h10, 4'd1, 2'd3, 4'd1, 8'h10},
    '{2'd1, 2'd0, 4'h0, 8'h40, 4'd6, 2'd3, 4'd1, 8'h10},
    '{2'd1, 2'd1, 4'h0, 8'h40, 4'd6, 2'd3, 4'd1, 8'h10},
    '{2'd1, 2'd2, 4'h0, 8'h40, 4'd6, 2'd3, 4'd1, 8'h20}, // R6 none taken
    '{2'd1, 2'd0, 4'hF, 8'h30, 4'd6, 2'd3, 4'd1, 8'h20},
    '{2'd1, 2'd1, 4'hF, 8'h30, 4'd6, 2'd3, 4'd1, 8'h20},
    '{2'd1, 2'd2, 4'hF, 8'h30, 4'd6, 2'd3, 4'd1, 8'h30}, // R6 all taken, static
    '{2'd2, 2'd0, 4'h0, 8'h00, 4'd8, 2'd3, 4'd1, 8'h30},
    '{2'd2, 2'd1, 4'h0, 8'h00, 4'd8, 2'd3, 4'd1, 8'h30},
    '{2'd2, 2'd2, 4'h0, 8'h00, 4'd8, 2'd0, 4'd0, 8'h00}
  };

  task automatic step(input logic [1:0] kind, input logic [1:0] slot,
                      input logic [3:0] mask, input logic [7:0] pc);
    @(negedge clk);
    start_i    = (kind == 2'd0);
    start_pc_i = pc;
    br_valid_i = (kind == 2'd1);
    br_slot_i  = slot;
    br_taken_i = mask;
    br_target_i = pc;
    rc_valid_i = (kind == 2'd2);
    rc_slot_i  = slot;
    @(negedge clk);
    start_i = 0; br_valid_i = 0; rc_valid_i = 0;
  endtask

  task automatic lane(input string req, input int k, input int l, input bit a, input int s);
    eq(req, int'(slot_act_o[k][l]), int'(a));
    if (a) eq(req, int'(slot_src_o[k][l]), s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    eq("R9 depth", int'(depth_o), 0);
    eq("R9 busy", int'(busy_o), 0);
    eq("R9 cnt", int'(warp_cnt_o), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].kind, TBL[i].slot, TBL[i].mask, TBL[i].pc);
      eq($sformatf("R%0d cnt v%0d", TBL[i].req, i), int'(warp_cnt_o), int'(TBL[i].cnt));
      eq($sformatf("R%0d depth v%0d", TBL[i].req, i), int'(depth_o), int'(TBL[i].depth));
      eq($sformatf("R%0d pc v%0d", TBL[i].req, i), int'(top_pc_o), int'(TBL[i].top));
    end

    // R1 static arrangement after launch
    step(2'd0, 2'd0, 4'h0, 8'h10);
    for (int k = 0; k < NW; k++)
      for (int l = 0; l < NL; l++) lane("R1 static", k, l, 1'b1, k);
    eq("R1 rpc", int'(top_rpc_o), 8'hFF);

    // R3 R4 R5 taken-path compaction
    step(2'd1, 2'd0, 4'h3, 8'h40);
    step(2'd1, 2'd1, 4'h6, 8'h40);
    step(2'd1, 2'd2, 4'h1, 8'h40);
    eq("R5 taken mask", int'(top_mask_o), 12'h163);
    eq("R5 taken rpc", int'(top_rpc_o), int'(RECONV));
    eq("R4 taken cnt", int'(warp_cnt_o), 2);
    eq("R4 slot valid", int'(slot_valid_o), 3'b011);
    lane("R3 t", 0, 0, 1, 0); lane("R3 t", 0, 1, 1, 0);
    lane("R3 t", 0, 2, 1, 1); lane("R3 t", 0, 3, 0, 0);
    lane("R3 t", 1, 0, 1, 2); lane("R3 t", 1, 1, 1, 1);
    lane("R3 t", 1, 2, 0, 0); lane("R3 t", 1, 3, 0, 0);

    // R1 launch while busy ignored
    step(2'd0, 2'd0, 4'h0, 8'h77);
    eq("R1 busy launch pc", int'(top_pc_o), 8'h40);
    eq("R1 busy launch depth", int'(depth_o), 3);

    // R7 R3 not-taken path after pop
    step(2'd2, 2'd0, 4'h0, 8'h00);
    step(2'd2, 2'd1, 4'h0, 8'h00);
    eq("R7 nt mask", int'(top_mask_o), 12'hE9C);
    eq("R7 nt pc", int'(top_pc_o), int'(FALL));
    eq("R4 nt cnt", int'(warp_cnt_o), 3);
    lane("R3 n", 0, 0, 1, 1); lane("R3 n", 0, 1, 1, 2);
    lane("R3 n", 0, 2, 1, 0); lane("R3 n", 0, 3, 1, 0);
    lane("R3 n", 1, 0, 0, 0); lane("R3 n", 1, 1, 0, 0);
    lane("R3 n", 1, 2, 1, 2); lane("R3 n", 1, 3, 1, 1);
    lane("R3 n", 2, 0, 0, 0); lane("R3 n", 2, 1, 0, 0);
    lane("R3 n", 2, 2, 0, 0); lane("R3 n", 2, 3, 1, 2);

    // R9 reset mid-flight
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    eq("R9 mid depth", int'(depth_o), 0);
    eq("R9 mid busy", int'(busy_o), 0);
    rst_ni = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule